// File: doc/BRIEF.md
# Power-Stage Fault Supervisor

This block decides, once per clock, whether a half-bridge power stage may switch. It watches a digitized supply-rail code and a digitized feedback code. It also watches two asynchronous comparator flags, one for an abnormal overcurrent and one for over-temperature. Switching starts only when the rail has risen past a start level. It stops when the rail sags below a lower stop level.

Faults fall into two classes. Overvoltage and a sustained overload are self-clearing faults. They cancel once the rail sags below the stop level, and switching then resumes when the rail climbs back to the start level. Abnormal overcurrent and over-temperature are sticky faults. They survive every rail level except a deep discharge below a clear level.

The overload fault is qualified by a programmable cycle count of continuously high feedback, so short load steps do not trip it. Every threshold comparison carries a small hysteresis. The outputs are a switching-enable, a prioritized fault code and a sticky-fault indicator.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: While reset is held and just after it is released, `sw_enable` is 0, `fault_code` is 0 (none) and `latched_flag` is 0.
- R2: With no fault, `sw_enable` goes to 1 on the second rising clock edge after `vsup_code` reaches V_START (default 140). It stays 0 while `vsup_code` is below V_START from the stopped state.
- R3: Once enabled, switching continues for any `vsup_code` at or above V_STOP (default 110). When the code falls below V_STOP, `sw_enable` drops on the second edge. After that, switching needs V_START again, and a code between the two levels keeps it stopped.
- R4: A `vsup_code` of V_OVP (default 230) or above sets `fault_code` 3 (overvoltage) on the second edge. This fault clears on the second edge after `vsup_code` falls below V_STOP.
- R5: While switching, `fb_code` held at or above FB_OLP (default 30) for OLP_DELAY (default 64) consecutive counted edges sets `fault_code` 4 (overload). This happens on edge OLP_DELAY+1 after the first edge that sees the high feedback. It clears in the same way as R4.
- R6: If feedback falls below FB_OLP-HYST (default 28) before the delay expires, the overload count restarts from zero and no fault is recorded.
- R7: A high `abn_oc_async` sets `fault_code` 1 and `latched_flag` 1 on the third edge, through a two-stage synchronizer. Both persist at every `vsup_code` of V_LATCH_CLR (default 50) or more. Both clear on the second edge after `vsup_code` falls below V_LATCH_CLR.
- R8: A high `over_temp_async` sets `fault_code` 2 and `latched_flag` 1 on the third edge. It persists and clears exactly as in R7.
- R9: When several faults are active, `fault_code` reports the highest priority: 1 before 2, 2 before 3, 3 before 4. While `latched_flag` is 1 the code is 1 or 2.
- R10: Each comparison has a hysteresis of HYST (default 2) codes. In particular, feedback that was high stays high down to FB_OLP-HYST, so the overload count continues at `fb_code` 29.
- R11: While any fault is recorded, `sw_enable` is 0 whatever the supply level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsup_code | input | CODE_W | Digitized supply rail |
| fb_code | input | CODE_W | Digitized feedback level |
| abn_oc_async | input | 1 | Abnormal-overcurrent comparator flag, asynchronous |
| over_temp_async | input | 1 | Over-temperature comparator flag, asynchronous |
| sw_enable | output | 1 | Switching allowed |
| fault_code | output | 3 | 0 none, 1 abnormal overcurrent, 2 over-temperature, 3 overvoltage, 4 overload |
| latched_flag | output | 1 | A sticky fault is recorded |

## Verification
A wrong run state or a comparator stuck on the wrong side of its hysteresis shows at `sw_enable` within two edges of the rail change that should have moved it. A sticky fault bit that clears on the wrong rail level shows at `fault_code` and `latched_flag` when the rail dips to the stop region rather than the deep-discharge region. An overload counter that fails to restart on a feedback drop trips the overload code too early. A counter that resets on the hysteresis band trips it too late. Either error is visible within OLP_DELAY edges, and the bench compares every port against its model on every clock.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_ABN_OC   = 3'd1,
      FLT_THERMAL  = 3'd2,
      FLT_OVERVOLT = 3'd3,
      FLT_OVERLOAD = 3'd4
   } pfs_fault_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pfs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfs_cmp_hyst.sv
module pfs_cmp_hyst #(
   parameter int CODE_W = 8,
   parameter int THRESH = 100,
   parameter int HYST   = 2,
   parameter bit ABOVE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              active
);
   localparam int CODE_MAX = (1 << CODE_W) - 1;

   if (THRESH < HYST || THRESH + HYST > CODE_MAX) begin : g_bad_thresh
      $error("pfs_cmp_hyst: THRESH and HYST do not fit the code range");
   end

   logic [CODE_W:0] code_x;
   logic            active_d;

   assign code_x = {1'b0, code};

   if (ABOVE) begin : g_above
      localparam logic [CODE_W:0] SET_LVL = (CODE_W+1)'(THRESH);
      localparam logic [CODE_W:0] REL_LVL = (CODE_W+1)'(THRESH - HYST);
      always_comb begin
         if (active) active_d = (code_x >= REL_LVL);
         else        active_d = (code_x >= SET_LVL);
      end
   end else begin : g_below
      localparam logic [CODE_W:0] SET_LVL = (CODE_W+1)'(THRESH);
      localparam logic [CODE_W:0] REL_LVL = (CODE_W+1)'(THRESH + HYST);
      always_comb begin
         if (active) active_d = (code_x < REL_LVL);
         else        active_d = (code_x < SET_LVL);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active <= 1'b0;
      else        active <= active_d;
   end
endmodule

// File: rtl/pfs_olp_timer.sv
module pfs_olp_timer #(
   parameter int OLP_DELAY = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fb_high,
   input  logic switching,
   output logic expired
);
   if (OLP_DELAY < 2) begin : g_bad_delay
      $error("pfs_olp_timer: OLP_DELAY must be at least 2");
   end

   localparam int CNT_W = $clog2(OLP_DELAY);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OLP_DELAY - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             counting;

   assign counting = fb_high && switching;
   assign expired  = counting && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (counting && !expired) cnt_q <= cnt_q + 1'b1;
      else                          cnt_q <= '0;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST) else $error("overload count out of range"); // R5
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !fb_high |=> cnt_q == '0) else $error("count kept after feedback drop"); // R6
endmodule

// File: rtl/pfs_fault_core.sv
module pfs_fault_core
   import pfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_hi,
   input  logic       below_stop,
   input  logic       below_clr,
   input  logic       ov_hi,
   input  logic       fb_hi,
   input  logic       olp_expired,
   input  logic       oc_sync,
   input  logic       ot_sync,
   output logic       switching,
   output pfs_fault_e code,
   output logic       sticky
);
   logic run_q;
   logic lat_oc_q, lat_ot_q;
   logic ar_ov_q, ar_ol_q;
   logic any_fault;

   assign any_fault = lat_oc_q || lat_ot_q || ar_ov_q || ar_ol_q;
   assign switching = run_q && !any_fault;
   assign sticky    = lat_oc_q || lat_ot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= 1'b0;
      else if (below_stop) run_q <= 1'b0;
      else if (start_hi)   run_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_oc_q <= 1'b0;
         lat_ot_q <= 1'b0;
      end else if (below_clr) begin
         lat_oc_q <= 1'b0;
         lat_ot_q <= 1'b0;
      end else begin
         if (oc_sync) lat_oc_q <= 1'b1;
         if (ot_sync) lat_ot_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_ov_q <= 1'b0;
         ar_ol_q <= 1'b0;
      end else if (below_stop) begin
         ar_ov_q <= 1'b0;
         ar_ol_q <= 1'b0;
      end else begin
         if (ov_hi)       ar_ov_q <= 1'b1;
         if (olp_expired) ar_ol_q <= 1'b1;
      end
   end

   always_comb begin
      if (lat_oc_q)      code = FLT_ABN_OC;
      else if (lat_ot_q) code = FLT_THERMAL;
      else if (ar_ov_q)  code = FLT_OVERVOLT;
      else if (ar_ol_q)  code = FLT_OVERLOAD;
      else               code = FLT_NONE;
   end

   AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> $past(start_hi)) else $error("run without start level"); // R2
   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      below_stop |=> !switching) else $error("switching below stop level"); // R3
   AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      below_stop |=> !(ar_ov_q || ar_ol_q)) else $error("auto fault kept"); // R4
   AST_OLP_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ar_ol_q) |-> $past(fb_hi)) else $error("overload without feedback"); // R5
   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && !below_clr) |=> sticky) else $error("sticky fault dropped"); // R7
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
   import pfs_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int V_START     = 140,
   parameter int V_STOP      = 110,
   parameter int V_LATCH_CLR = 50,
   parameter int V_OVP       = 230,
   parameter int FB_OLP      = 30,
   parameter int HYST        = 2,
   parameter int OLP_DELAY   = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] vsup_code,
   input  logic [CODE_W-1:0] fb_code,
   input  logic              abn_oc_async,
   input  logic              over_temp_async,
   output logic              sw_enable,
   output logic [2:0]        fault_code,
   output logic              latched_flag
);
   if (!(V_LATCH_CLR + HYST < V_STOP && V_STOP + HYST < V_START && V_START < V_OVP))
   begin : g_bad_order
      $error("pwr_fault_supervisor: supply thresholds out of order");
   end

   logic start_hi, below_stop, below_clr, ov_hi, fb_hi;
   logic oc_sync, ot_sync, olp_expired, switching;
   pfs_fault_e code;

   pfs_cmp_hyst #(.CODE_W(CODE_W), .THRESH(V_START), .HYST(HYST), .ABOVE(1'b1))
      i_cmp_start (.clk(clk), .rst_n(rst_n), .code(vsup_code), .active(start_hi));
   pfs_cmp_hyst #(.CODE_W(CODE_W), .THRESH(V_STOP), .HYST(HYST), .ABOVE(1'b0))
      i_cmp_stop (.clk(clk), .rst_n(rst_n), .code(vsup_code), .active(below_stop));
   pfs_cmp_hyst #(.CODE_W(CODE_W), .THRESH(V_LATCH_CLR), .HYST(HYST), .ABOVE(1'b0))
      i_cmp_clr (.clk(clk), .rst_n(rst_n), .code(vsup_code), .active(below_clr));
   pfs_cmp_hyst #(.CODE_W(CODE_W), .THRESH(V_OVP), .HYST(HYST), .ABOVE(1'b1))
      i_cmp_ovp (.clk(clk), .rst_n(rst_n), .code(vsup_code), .active(ov_hi));
   pfs_cmp_hyst #(.CODE_W(CODE_W), .THRESH(FB_OLP), .HYST(HYST), .ABOVE(1'b1))
      i_cmp_fb (.clk(clk), .rst_n(rst_n), .code(fb_code), .active(fb_hi));

   pfs_sync #(.STAGES(SYNC_STAGES))
      i_sync_oc (.clk(clk), .rst_n(rst_n), .d_async(abn_oc_async), .q_sync(oc_sync));
   pfs_sync #(.STAGES(SYNC_STAGES))
      i_sync_ot (.clk(clk), .rst_n(rst_n), .d_async(over_temp_async), .q_sync(ot_sync));

   pfs_olp_timer #(.OLP_DELAY(OLP_DELAY))
      i_olp (.clk(clk), .rst_n(rst_n), .fb_high(fb_hi), .switching(switching),
             .expired(olp_expired));

   pfs_fault_core i_core (
      .clk(clk), .rst_n(rst_n), .start_hi(start_hi), .below_stop(below_stop),
      .below_clr(below_clr), .ov_hi(ov_hi), .fb_hi(fb_hi), .olp_expired(olp_expired),
      .oc_sync(oc_sync), .ot_sync(ot_sync), .switching(switching), .code(code),
      .sticky(latched_flag));

   assign sw_enable  = switching;
   assign fault_code = code;

   AST_FAULT_BLOCKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      fault_code != 3'd0 |-> !sw_enable) else $error("enabled while faulted"); // R11
   AST_STICKY_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      latched_flag |-> (fault_code == 3'd1 || fault_code == 3'd2))
      else $error("sticky fault not reported first"); // R9
endmodule

// File: tb/test_pwr_fault_supervisor.sv
`timescale 1ns/1ps
module test_pwr_fault_supervisor;
   localparam int D = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] vsup = 8'd0, fb = 8'd0;
   logic       oc = 1'b0, ot = 1'b0;
   logic       en;
   logic [2:0] code;
   logic       lat;

   int errors = 0, checks = 0;
   bit done = 1'b0;
   string phase = "R1";

   always #10 clk = ~clk;

   pwr_fault_supervisor i_pwr_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .vsup_code(vsup), .fb_code(fb),
      .abn_oc_async(oc), .over_temp_async(ot),
      .sw_enable(en), .fault_code(code), .latched_flag(lat));

   // behavioural reference
   bit m_start, m_stop, m_clr, m_ov, m_fb, m_run;
   bit m_loc, m_lot, m_aov, m_aol;
   bit q_oc[$], q_ot[$];
   int m_cnt;

   function automatic int exp_code();
      if (m_loc) return 1;
      if (m_lot) return 2;
      if (m_aov) return 3;
      if (m_aol) return 4;
      return 0;
   endfunction

   function automatic bit exp_en();
      return m_run && !(m_loc || m_lot || m_aov || m_aol);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_start, m_stop, m_clr, m_ov, m_fb, m_run} = '0;
         {m_loc, m_lot, m_aov, m_aol} = '0;
         m_cnt = 0;
         q_oc = '{0, 0};
         q_ot = '{0, 0};
      end else begin
         bit e, so, st;
         e = exp_en();
         so = q_oc[0];
         st = q_ot[0];
         if (m_stop) m_run = 0; else if (m_start) m_run = 1;
         if (m_clr) begin m_loc = 0; m_lot = 0; end
         else begin if (so) m_loc = 1; if (st) m_lot = 1; end
         if (m_stop) begin m_aov = 0; m_aol = 0; end
         else begin
            if (m_ov) m_aov = 1;
            if (m_fb && e && m_cnt == D-1) m_aol = 1;
         end
         if (m_fb && e && m_cnt != D-1) m_cnt++; else m_cnt = 0;
         m_start = m_start ? (vsup >= 138) : (vsup >= 140);
         m_stop  = m_stop  ? (vsup < 112)  : (vsup < 110);
         m_clr   = m_clr   ? (vsup < 52)   : (vsup < 50);
         m_ov    = m_ov    ? (vsup >= 228) : (vsup >= 230);
         m_fb    = m_fb    ? (fb >= 28)    : (fb >= 30);
         void'(q_oc.pop_front()); q_oc.push_back(oc);
         void'(q_ot.pop_front()); q_ot.push_back(ot);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (en !== exp_en() || code !== 3'(exp_code()) || lat !== (m_loc || m_lot)) begin
            errors++;
            $display("FAIL %s model: en=%0b code=%0d lat=%0b expected en=%0b code=%0d lat=%0b",
                     phase, en, code, lat, exp_en(), exp_code(), m_loc || m_lot);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_eq(int act, int expv, string tag);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      expect_eq(en, 0, "R1 enable"); expect_eq(code, 0, "R1 code"); expect_eq(lat, 0, "R1 latched");
      phase = "R2"; vsup = 8'd139; tick(6); expect_eq(en, 0, "R2 below start");
      vsup = 8'd145; tick(1); expect_eq(en, 0, "R2 first edge");
      tick(1); expect_eq(en, 1, "R2 second edge");
      phase = "R3"; vsup = 8'd112; tick(5); expect_eq(en, 1, "R3 between levels");
      vsup = 8'd109; tick(1); expect_eq(en, 1, "R3 first edge");
      tick(1); expect_eq(en, 0, "R3 stopped");
      vsup = 8'd130; tick(5); expect_eq(en, 0, "R3 needs start again");
      vsup = 8'd145; tick(2); expect_eq(en, 1, "R3 restart");
      phase = "R6"; fb = 8'd35; tick(30); fb = 8'd20; tick(5); fb = 8'd35; tick(40);
      expect_eq(code, 0, "R6 transient no trip"); expect_eq(en, 1, "R6 still running");
      fb = 8'd0; tick(3);
      phase = "R10"; fb = 8'd35; tick(10); fb = 8'd29; tick(50);
      expect_eq(code, 0, "R10 counting in band");
      tick(10); expect_eq(code, 4, "R5 R10 overload trip");
      expect_eq(en, 0, "R11 overload blocks enable");
      fb = 8'd0; phase = "R4";
      vsup = 8'd100; tick(2); expect_eq(code, 0, "R5 auto clear");
      vsup = 8'd145; tick(2); expect_eq(en, 1, "R4 resume");
      vsup = 8'd235; tick(1); expect_eq(code, 0, "R4 first edge");
      tick(1); expect_eq(code, 3, "R4 overvoltage"); expect_eq(en, 0, "R4 enable low");
      phase = "R11"; vsup = 8'd200; tick(4); expect_eq(code, 3, "R11 fault held"); expect_eq(en, 0, "R11 enable low");
      vsup = 8'd100; tick(2); expect_eq(code, 0, "R4 clear");
      vsup = 8'd145; tick(2); expect_eq(en, 1, "R4 restart");
      phase = "R9"; vsup = 8'd235; ot = 1'b1;
      tick(2); expect_eq(code, 3, "R9 overvoltage first");
      tick(1); expect_eq(code, 2, "R9 thermal over overvoltage"); expect_eq(lat, 1, "R9 latched");
      oc = 1'b1; tick(3); expect_eq(code, 1, "R9 overcurrent over thermal");
      oc = 1'b0; ot = 1'b0; phase = "R7"; vsup = 8'd100; tick(4);
      expect_eq(code, 1, "R7 survives stop dip"); expect_eq(lat, 1, "R7 latched"); expect_eq(en, 0, "R7 enable low");
      vsup = 8'd45; tick(2); expect_eq(code, 0, "R7 deep clear"); expect_eq(lat, 0, "R7 latched clear");
      vsup = 8'd145; tick(2); expect_eq(en, 1, "R7 restart");
      phase = "R8"; ot = 1'b1; tick(2); expect_eq(code, 0, "R8 sync delay");
      tick(1); expect_eq(code, 2, "R8 thermal"); expect_eq(lat, 1, "R8 latched");
      ot = 1'b0; vsup = 8'd100; tick(3); expect_eq(code, 2, "R8 survives dip");
      vsup = 8'd40; tick(2); expect_eq(code, 0, "R8 deep clear");
      vsup = 8'd145; tick(2);
      phase = "R7"; oc = 1'b1; tick(2); expect_eq(code, 0, "R7 sync delay");
      tick(1); expect_eq(code, 1, "R7 overcurrent"); oc = 1'b0;
      vsup = 8'd50; tick(4); expect_eq(code, 1, "R7 holds at clear level");
      vsup = 8'd49; tick(2); expect_eq(code, 0, "R7 clears below level");
      tick(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule